// File: doc/BRIEF.md
# Signed/Unsigned Recursive Vedic Multiplier

This block multiplies two operands of equal width and returns a product twice that width. A one-bit mode input chooses how both operands are read. At 0 they are plain unsigned binary numbers. At 1 they are two's-complement numbers. The same array hardware serves both modes.

The product does not come from a behavioural multiply or a shift-and-add loop. It comes from the vertical-and-crosswise decomposition. A 2x2 gate cell is the leaf. Each larger stage splits its operands into halves and forms four half-width products. It adds them at weights 0, half and full. In signed mode, negative operands are turned into magnitudes in front of the array. The unsigned result is negated behind the array when exactly one operand was negative.

A single register with a synchronous active-low reset holds the result at the output. The width parameter defaults to 8, which gives 19 input pins and 16 output pins. The same code builds 4- and 16-bit versions.

Top module: `vedic_mul`

## Requirements
- R1: With `signed_en` = 0, `product` equals the unsigned product of `mcand` and `mplier`, for every operand pair.
- R2: With `signed_en` = 1, `product` equals the two's-complement product of `mcand` and `mplier`, read as signed numbers, for every operand pair.
- R3: Mode encoding is 1 = signed and 0 = unsigned. For example, 0xFF x 0xFF gives 0xFE01 in unsigned mode and 0x0001 in signed mode.
- R4: In signed mode, the most negative value squared (0x80 x 0x80 at 8 bits) gives the positive value 2^(2W-2), which is 0x4000 at 8 bits.
- R5: In signed mode, a nonzero product has its top bit equal to the XOR of the two operand sign bits.
- R6: If either operand is zero, the product is zero in both modes.
- R7: `product` takes the result of the operands and mode one rising clock edge after they are presented. It does not change between edges.
- R8: While `rst_n` is low, a rising edge clears `product` to zero. Lowering `rst_n` between edges leaves `product` unchanged until the next rising edge.
- R9: The width parameter `W` may be 4, 8 or 16. The 4-bit build meets R1 and R2 for every operand pair.
- R10: In unsigned mode, a multiplier of 1 returns the multiplicand zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears the product |
| signed_en | input | 1 | 1 = two's-complement operands, 0 = unsigned operands |
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier |
| product | output | 2W | Registered product |

## Verification
The bench builds two instances of the block: one at the default width of 8 and one at a width of 4. At 8 bits, every one of the 65,536 operand pairs is run in both modes. This covers each sign combination, the most-negative corner and the zero and unit operands over the full recursion depth of the 2x2 to 4x4 to 8x8 tree. The 4-bit instance is swept exhaustively as well. It exercises the parameterised recursion at a second depth, where a single split sits above the leaf cells. Directed steps around the reset and the clock edge then show when the register captures and clears.

// File: rtl/vedic_mul_pkg.sv
// Package: shared definitions for the recursive multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package vedic_mul_pkg;
    // Operand interpretation selected by the mode pin.
    typedef enum logic {
        MUL_UNSIGNED = 1'b0,
        MUL_SIGNED   = 1'b1
    } mul_mode_e;
endpackage

// File: rtl/vm_cell2.sv
// vm_cell2: 2x2 unsigned multiplier built from gates; the leaf of the tree.
// Assumes: plain unsigned 2-bit operands; purely combinational.
module vm_cell2 (
    input  logic [1:0] x,
    input  logic [1:0] y,
    output logic [3:0] p
);
    logic cross_c;

    // Vertical terms on the ends, crosswise pair in the middle with its carry.
    always_comb begin
        p[0]    = x[0] & y[0];
        p[1]    = (x[1] & y[0]) ^ (x[0] & y[1]);
        cross_c = (x[1] & y[0]) & (x[0] & y[1]);
        p[2]    = (x[1] & y[1]) ^ cross_c;
        p[3]    = (x[1] & y[1]) & cross_c;
    end
endmodule

// File: rtl/vm_array.sv
// vm_array: NxN unsigned multiplier built by recursive halving.
// Each level forms four (N/2)x(N/2) products: low*low at weight 0,
// the two cross products at weight N/2, high*high at weight N.
// Assumes: N is a power of two, at least 2; combinational.
module vm_array #(
    parameter int N = 8
) (
    input  logic [N-1:0]   x,
    input  logic [N-1:0]   y,
    output logic [2*N-1:0] p
);
    generate
        if (N == 2) begin : g_leaf
            vm_cell2 u_cell (.x(x), .y(y), .p(p));
        end else begin : g_split
            localparam int H = N / 2;
            logic [N-1:0]   pp_ll, pp_lh, pp_hl, pp_hh;
            logic [N:0]     cross_sum;
            logic [2*N-1:0] cross_ext;

            vm_array #(.N(H)) u_ll (.x(x[H-1:0]), .y(y[H-1:0]), .p(pp_ll));
            vm_array #(.N(H)) u_lh (.x(x[H-1:0]), .y(y[N-1:H]), .p(pp_lh));
            vm_array #(.N(H)) u_hl (.x(x[N-1:H]), .y(y[H-1:0]), .p(pp_hl));
            vm_array #(.N(H)) u_hh (.x(x[N-1:H]), .y(y[N-1:H]), .p(pp_hh));

            // Merge: vertical terms concatenate, crosswise sum lands at weight H.
            always_comb begin
                cross_sum = {1'b0, pp_lh} + {1'b0, pp_hl};
                cross_ext = {{(N-1){1'b0}}, cross_sum} << H;
                p         = {pp_hh, pp_ll} + cross_ext;
            end
        end
    endgenerate
endmodule

// File: rtl/vm_sign_front.sv
// vm_sign_front: turns an operand into its magnitude for the unsigned array.
// Assumes: the most negative value maps to 2^(W-1), read as unsigned,
// which fits in W bits, so no extra bit is needed.
module vm_sign_front #(
    parameter int W = 8
) (
    input  logic [W-1:0] op,
    input  logic         signed_en,
    output logic [W-1:0] mag,
    output logic         neg
);
    // Negate only when signed mode sees a set sign bit.
    always_comb begin
        neg = signed_en & op[W-1];
        mag = neg ? (~op + 1'b1) : op;
    end
endmodule

// File: rtl/vm_sign_back.sv
// vm_sign_back: restores the sign of the product after the unsigned array.
// Assumes: the magnitude product is at most 2^(2W-2) when flip can be set.
module vm_sign_back #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] uprod,
    input  logic           flip,
    output logic [2*W-1:0] sprod
);
    // Two's-complement negation when exactly one operand was negative.
    always_comb begin
        sprod = flip ? (~uprod + 1'b1) : uprod;
    end
endmodule

// File: rtl/vedic_mul.sv
// vedic_mul: top level. Sign front end, recursive array, sign back end
// and a registered output.
// Assumes: W is 4, 8 or 16; rst_n is synchronous and active low.
module vedic_mul
    import vedic_mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           signed_en,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] product
);
    localparam int PW = 2 * W;
    localparam logic [PW-1:0] MIN_SQ = {{(PW-1){1'b0}}, 1'b1} << (PW - 2);
    localparam logic [W-1:0]  MIN_OP = {1'b1, {(W-1){1'b0}}};

    mul_mode_e       mode;
    logic [W-1:0]    mag_a, mag_b;
    logic            neg_a, neg_b;
    logic [PW-1:0]   mag_prod, next_prod;

    // Map the mode pin onto the package encoding.
    always_comb mode = mul_mode_e'(signed_en);

    vm_sign_front #(.W(W)) u_front_a (
        .op(mcand), .signed_en(mode == MUL_SIGNED), .mag(mag_a), .neg(neg_a));
    vm_sign_front #(.W(W)) u_front_b (
        .op(mplier), .signed_en(mode == MUL_SIGNED), .mag(mag_b), .neg(neg_b));

    vm_array #(.N(W)) u_array (.x(mag_a), .y(mag_b), .p(mag_prod));

    vm_sign_back #(.W(W)) u_back (
        .uprod(mag_prod), .flip(neg_a ^ neg_b), .sprod(next_prod));

    // Output register: clear under reset, otherwise capture the new product.
    always_ff @(posedge clk) begin
        if (!rst_n) product <= '0;
        else        product <= next_prod;
    end

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (mcand == '0 || mplier == '0) |=> product == '0); // R6

    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (signed_en && mcand != '0 && mplier != '0)
        |=> product[PW-1] == ($past(mcand[W-1]) ^ $past(mplier[W-1]))); // R5

    AST_MIN_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
        (signed_en && mcand == MIN_OP && mplier == MIN_OP)
        |=> product == MIN_SQ); // R4

    AST_UNIT_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (!signed_en && mplier == {{(W-1){1'b0}}, 1'b1})
        |=> product == {{W{1'b0}}, $past(mcand)}); // R10

    AST_MAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        signed_en |-> mag_prod <= MIN_SQ); // R2
endmodule

// File: tb/vedic_mul_test.sv
`timescale 1ns/1ps
// vedic_mul_test: table walk, exhaustive sweeps at W=8 and W=4,
// then directed tests on timing and reset.
module vedic_mul_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sg8 = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] p8;
    logic        sg4 = 1'b0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  p4;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    vedic_mul #(.W(8)) uut  (.clk(clk), .rst_n(rst_n), .signed_en(sg8),
                             .mcand(a8), .mplier(b8), .product(p8));
    vedic_mul #(.W(4)) uut4 (.clk(clk), .rst_n(rst_n), .signed_en(sg4),
                             .mcand(a4), .mplier(b4), .product(p4));

    // Entry layout: {mode, a, b, expected}
    localparam logic [32:0] VEC [14] = '{
        {1'b0, 8'h00, 8'h00, 16'h0000},
        {1'b0, 8'hFF, 8'hFF, 16'hFE01},
        {1'b1, 8'hFF, 8'hFF, 16'h0001},
        {1'b1, 8'h80, 8'h80, 16'h4000},
        {1'b1, 8'h80, 8'h7F, 16'hC080},
        {1'b1, 8'h7F, 8'h7F, 16'h3F01},
        {1'b1, 8'h80, 8'h01, 16'hFF80},
        {1'b0, 8'h80, 8'h80, 16'h4000},
        {1'b1, 8'hFF, 8'h01, 16'hFFFF},
        {1'b0, 8'hC8, 8'h01, 16'h00C8},
        {1'b1, 8'h00, 8'h80, 16'h0000},
        {1'b0, 8'h0F, 8'h10, 16'h00F0},
        {1'b1, 8'hFE, 8'h03, 16'hFFFA},
        {1'b0, 8'h80, 8'hFF, 16'h7F80}
    };
    localparam string TAG [14] = '{"R6", "R3", "R3", "R4", "R5", "R2", "R5",
                                   "R1", "R2", "R10", "R6", "R1", "R5", "R1"};

    // Reference product at 8 bits, from the arithmetic definition.
    function automatic logic [15:0] ref8(logic m, logic [7:0] a, logic [7:0] b);
        logic [15:0] ea, eb;
        ea = m ? {{8{a[7]}}, a} : {8'h00, a};
        eb = m ? {{8{b[7]}}, b} : {8'h00, b};
        return ea * eb;
    endfunction

    // Reference product at 4 bits.
    function automatic logic [7:0] ref4(logic m, logic [3:0] a, logic [3:0] b);
        logic [7:0] ea, eb;
        ea = m ? {{4{a[3]}}, a} : {4'h0, a};
        eb = m ? {{4{b[3]}}, b} : {4'h0, b};
        return ea * eb;
    endfunction

    // Count one check; on mismatch print a single FAIL line.
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp8;
        logic [7:0]  exp4;
        logic        have;
        string       req;

        // Reset state (R8)
        repeat (2) @(negedge clk);
        chk("R8", 32'(p8), 32'h0);
        chk("R8", 32'(p4), 32'h0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            {sg8, a8, b8} = VEC[i][32:16];
            @(negedge clk);
            chk(TAG[i], 32'(p8), 32'(VEC[i][15:0]));
        end

        // Exhaustive sweep at W=8, pipelined one result per cycle (R1, R2)
        have = 1'b0;
        exp8 = '0;
        req  = "R1";
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    @(negedge clk);
                    if (have) chk(req, 32'(p8), 32'(exp8));
                    sg8 = m[0]; a8 = a[7:0]; b8 = b[7:0];
                    exp8 = ref8(m[0], a[7:0], b[7:0]);
                    req  = m[0] ? "R2" : "R1";
                    have = 1'b1;
                end
            end
        end
        @(negedge clk);
        chk(req, 32'(p8), 32'(exp8));

        // Exhaustive sweep at W=4 (R9)
        have = 1'b0;
        exp4 = '0;
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    @(negedge clk);
                    if (have) chk("R9", 32'(p4), 32'(exp4));
                    sg4 = m[0]; a4 = a[3:0]; b4 = b[3:0];
                    exp4 = ref4(m[0], a[3:0], b[3:0]);
                    have = 1'b1;
                end
            end
        end
        @(negedge clk);
        chk("R9", 32'(p4), 32'(exp4));
        chk("R9", 32'(p4), 32'h01);   // signed 0xF x 0xF = +1 at 4 bits

        // One-edge latency and hold between edges (R7)
        @(negedge clk);
        sg8 = 1'b0; a8 = 8'd3; b8 = 8'd5;
        @(negedge clk);
        chk("R7", 32'(p8), 32'd15);
        a8 = 8'd7;
        #2;
        chk("R7", 32'(p8), 32'd15);
        @(negedge clk);
        chk("R7", 32'(p8), 32'd35);

        // Synchronous clear (R8)
        rst_n = 1'b0;
        #2;
        chk("R8", 32'(p8), 32'd35);
        @(negedge clk);
        chk("R8", 32'(p8), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", 32'(p8), 32'd35);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule